// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block is the trap-control slice of a small 32-bit processor. It keeps the processor status word, a saved copy of it, a per-line interrupt mask, and a registered view of the interrupt lines that the mask lets through. At every instruction boundary the pipeline reports to it, the block decides whether to take an interrupt. When it takes one, it saves the status word and clears the global enable bit. It also issues a write of the following instruction's address into the exception-return register of the register file, and sends fetch to a fixed handler address.

A return-from-exception command undoes the entry. The saved status word goes back into the status register and fetch goes to the return address, which the register file supplies. Software reads and writes the control registers through a small write port and a registered read port. Entry and return take priority over any software write to the same registers in that cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When an interrupt is taken, the complete status word as it stood before entry is copied into the saved-status register on the same clock edge.
- R2: Entry clears status bit 0 (the global enable) and leaves every other status bit unchanged.
- R3: On the edge after the decision, entry raises `ea_we_o` for exactly one cycle, with `ea_idx_o` = 29 and `ea_data_o` = `next_pc_i` as sampled in the decision cycle.
- R4: On that same edge, entry raises `redirect_o` for exactly one cycle with `redirect_pc_o` = 0x00000020.
- R5: A cycle with `eret_i` high copies saved-status back into status on the next edge and raises `redirect_o` for one cycle with `redirect_pc_o` = `ea_in_i`, with `ea_we_o` low.
- R6: Reading control address 3 returns the interrupt lines ANDed with the mask register, zero-extended. The lines are registered once before this value, and the read port adds one more cycle.
- R7: An interrupt is taken only in a cycle where `boundary_i` is high, status bit 0 is 1, and the registered masked lines are not zero. Otherwise no redirect and no return-address write occur.
- R8: Control addresses are 0 = status, 1 = saved-status, 2 = interrupt mask, 3 = masked pending lines (read-only; writes to it have no effect). A write to status takes effect at the edge, so setting bit 0 allows an interrupt at the next boundary.
- R9: After reset, status, saved-status, mask and pending read as zero, and `redirect_o`, `ea_we_o` and `pie_o` are low.
- R10: If `eret_i` and an otherwise takeable boundary occur in the same cycle, the return wins. When entry or return happens, a software write to status or saved-status in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | IRQ_N | Interrupt request lines; line n is gated by mask bit n |
| boundary_i | input | 1 | Instruction boundary strobe; an interrupt may be taken in this cycle |
| next_pc_i | input | ADDR_W | Address of the instruction after the current one |
| eret_i | input | 1 | Return-from-exception command |
| ea_in_i | input | ADDR_W | Current contents of the exception-return register |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_waddr_i | input | 2 | Control register write address |
| ctl_wdata_i | input | DATA_W | Control register write data |
| ctl_raddr_i | input | 2 | Control register read address |
| ctl_rdata_o | output | DATA_W | Registered read data, one cycle after the address |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | ADDR_W | Target fetch address for the redirect |
| ea_we_o | output | 1 | Register-file write strobe for the return address |
| ea_idx_o | output | 5 | Register index for that write (29) |
| ea_data_o | output | ADDR_W | Return address to write |
| pie_o | output | 1 | Current global interrupt enable (status bit 0) |

## Verification
The bench checks that a second boundary, with a line still asserted after entry, is refused. A design that failed to clear the enable bit would re-enter the handler at once and overwrite the saved status. It drives a return and a takeable interrupt in the same cycle: a wrong priority would redirect to the vector and lose the return. It writes status in the entry cycle, which a design that let software win would use to re-enable interrupts inside the handler. It checks that a status word with upper bits set is saved in full and gets back only its enable bit on return, which catches a design that saves or restores only bit 0.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int CSR_AW = 2;

  typedef enum logic [CSR_AW-1:0] {
    CSR_STATUS  = 2'd0,
    CSR_SAVED   = 2'd1,
    CSR_MASK    = 2'd2,
    CSR_PENDING = 2'd3
  } csr_sel_e;

  localparam int PIE_BIT = 0;
endpackage

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_N  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_i,
  input  logic              leave_i,
  input  logic              wr_en_i,
  input  logic [CSR_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] saved_o,
  output logic [IRQ_N-1:0]  mask_o
);
  logic [DATA_W-1:0] status_q, saved_q;
  logic [IRQ_N-1:0]  mask_q;
  logic              sw_status, sw_saved, sw_mask;

  always_comb begin
    sw_status = wr_en_i && (wr_addr_i == CSR_STATUS);
    sw_saved  = wr_en_i && (wr_addr_i == CSR_SAVED);
    sw_mask   = wr_en_i && (wr_addr_i == CSR_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      saved_q  <= '0;
    end else if (leave_i) begin
      status_q <= saved_q;
    end else if (enter_i) begin
      saved_q  <= status_q;
      status_q <= status_q & ~(DATA_W'(1) << PIE_BIT);
    end else begin
      if (sw_status) status_q <= wr_data_i;
      if (sw_saved)  saved_q  <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (sw_mask) mask_q <= wr_data_i[IRQ_N-1:0];
  end

  assign status_o = status_q;
  assign saved_o  = saved_q;
  assign mask_o   = mask_q;

  AST_ENTRY_SAVES_STATUS: assert property (@(posedge clk) disable iff (rst)
    enter_i && !leave_i |=> saved_q == $past(status_q)); // R1
  AST_ENTRY_CLEARS_PIE: assert property (@(posedge clk) disable iff (rst)
    enter_i && !leave_i |=> !status_q[PIE_BIT] &&
      (status_q >> 1) == ($past(status_q) >> 1)); // R2
  AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (rst)
    leave_i |=> status_q == $past(saved_q)); // R5
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    sw_mask |=> mask_q == $past(wr_data_i[IRQ_N-1:0])); // R8
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int IRQ_N = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_N-1:0] irq_i,
  input  logic [IRQ_N-1:0] mask_i,
  input  logic             pie_i,
  input  logic             boundary_i,
  input  logic             eret_i,
  output logic [IRQ_N-1:0] pending_o,
  output logic             take_o
);
  logic [IRQ_N-1:0] pending_q;

  always_ff @(posedge clk) begin
    if (rst) pending_q <= '0;
    else     pending_q <= irq_i & mask_i;
  end

  always_comb begin
    take_o = boundary_i && !eret_i && pie_i && (|pending_q);
  end

  assign pending_o = pending_q;

  AST_PENDING_MASKED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pending_q & ~$past(mask_i)) == '0); // R6
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect #(
  parameter int          ADDR_W    = 32,
  parameter int          REG_IDX_W = 5,
  parameter int          EA_IDX    = 29,
  parameter logic [31:0] VECTOR    = 32'h0000_0020
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take_i,
  input  logic                 eret_i,
  input  logic [ADDR_W-1:0]    next_pc_i,
  input  logic [ADDR_W-1:0]    ea_in_i,
  output logic                 redirect_o,
  output logic [ADDR_W-1:0]    redirect_pc_o,
  output logic                 ea_we_o,
  output logic [REG_IDX_W-1:0] ea_idx_o,
  output logic [ADDR_W-1:0]    ea_data_o
);
  localparam logic [ADDR_W-1:0]    VEC_A = VECTOR[ADDR_W-1:0];
  localparam logic [REG_IDX_W-1:0] IDX_C = REG_IDX_W'(EA_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      ea_we_o       <= 1'b0;
      ea_data_o     <= '0;
    end else if (eret_i) begin
      redirect_o    <= 1'b1;
      redirect_pc_o <= ea_in_i;
      ea_we_o       <= 1'b0;
    end else if (take_i) begin
      redirect_o    <= 1'b1;
      redirect_pc_o <= VEC_A;
      ea_we_o       <= 1'b1;
      ea_data_o     <= next_pc_i;
    end else begin
      redirect_o    <= 1'b0;
      ea_we_o       <= 1'b0;
    end
  end

  assign ea_idx_o = IDX_C;

  AST_EA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    take_i && !eret_i |=> ea_we_o && ea_data_o == $past(next_pc_i)); // R3
  AST_VECTOR_JUMP: assert property (@(posedge clk) disable iff (rst)
    take_i && !eret_i |=> redirect_o && redirect_pc_o == VEC_A); // R4
  AST_RETURN_JUMP: assert property (@(posedge clk) disable iff (rst)
    eret_i |=> redirect_o && !ea_we_o && redirect_pc_o == $past(ea_in_i)); // R5
  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (rst)
    !take_i && !eret_i |=> !redirect_o && !ea_we_o); // R7
endmodule

// File: rtl/exc_read_port.sv
module exc_read_port
  import exc_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_N  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CSR_AW-1:0] raddr_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] saved_i,
  input  logic [IRQ_N-1:0]  mask_i,
  input  logic [IRQ_N-1:0]  pending_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mask_ext, pend_ext;

  always_comb begin
    mask_ext = '0;
    pend_ext = '0;
    mask_ext[IRQ_N-1:0] = mask_i;
    pend_ext[IRQ_N-1:0] = pending_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      unique case (csr_sel_e'(raddr_i))
        CSR_STATUS:  rdata_o <= status_i;
        CSR_SAVED:   rdata_o <= saved_i;
        CSR_MASK:    rdata_o <= mask_ext;
        CSR_PENDING: rdata_o <= pend_ext;
        default:     rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 32,
  parameter int          IRQ_N     = 32,
  parameter int          EA_IDX    = 29,
  parameter logic [31:0] VECTOR    = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IRQ_N-1:0]  irq_i,
  input  logic              boundary_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic              eret_i,
  input  logic [ADDR_W-1:0] ea_in_i,
  input  logic              ctl_we_i,
  input  logic [1:0]        ctl_waddr_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  input  logic [1:0]        ctl_raddr_i,
  output logic [DATA_W-1:0] ctl_rdata_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic              ea_we_o,
  output logic [4:0]        ea_idx_o,
  output logic [ADDR_W-1:0] ea_data_o,
  output logic              pie_o
);
  localparam int REG_IDX_W = 5;

  logic [DATA_W-1:0] status_w, saved_w;
  logic [IRQ_N-1:0]  mask_w, pending_w;
  logic              take_w;

  exc_state_regs #(.DATA_W(DATA_W), .IRQ_N(IRQ_N)) u_regs (
    .clk(clk), .rst(rst),
    .enter_i(take_w), .leave_i(eret_i),
    .wr_en_i(ctl_we_i), .wr_addr_i(ctl_waddr_i), .wr_data_i(ctl_wdata_i),
    .status_o(status_w), .saved_o(saved_w), .mask_o(mask_w)
  );

  exc_irq_gate #(.IRQ_N(IRQ_N)) u_gate (
    .clk(clk), .rst(rst),
    .irq_i(irq_i), .mask_i(mask_w), .pie_i(status_w[PIE_BIT]),
    .boundary_i(boundary_i), .eret_i(eret_i),
    .pending_o(pending_w), .take_o(take_w)
  );

  exc_redirect #(.ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W),
                 .EA_IDX(EA_IDX), .VECTOR(VECTOR)) u_redir (
    .clk(clk), .rst(rst),
    .take_i(take_w), .eret_i(eret_i),
    .next_pc_i(next_pc_i), .ea_in_i(ea_in_i),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .ea_we_o(ea_we_o), .ea_idx_o(ea_idx_o), .ea_data_o(ea_data_o)
  );

  exc_read_port #(.DATA_W(DATA_W), .IRQ_N(IRQ_N)) u_rd (
    .clk(clk), .rst(rst),
    .raddr_i(ctl_raddr_i),
    .status_i(status_w), .saved_i(saved_w),
    .mask_i(mask_w), .pending_i(pending_w),
    .rdata_o(ctl_rdata_o)
  );

  assign pie_o = status_w[PIE_BIT];

  AST_NO_TAKE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !pie_o |-> !take_w); // R7
  AST_RETURN_BEATS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    eret_i |-> !take_w); // R10
  AST_ENTRY_BLOCKS_SW: assert property (@(posedge clk) disable iff (rst)
    take_w && !eret_i |=> !pie_o); // R10
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  localparam int DW = 32;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   irq = '0;
  logic          boundary = 1'b0;
  logic [31:0]   next_pc = '0;
  logic          eret = 1'b0;
  logic [31:0]   ea_in = '0;
  logic          we = 1'b0;
  logic [1:0]    waddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    raddr = '0;
  logic [DW-1:0] rdata;
  logic          redirect, ea_we, pie;
  logic [31:0]   redirect_pc, ea_data;
  logic [4:0]    ea_idx;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  exc_entry_ctrl uut (
    .clk(clk), .rst(rst), .irq_i(irq), .boundary_i(boundary),
    .next_pc_i(next_pc), .eret_i(eret), .ea_in_i(ea_in),
    .ctl_we_i(we), .ctl_waddr_i(waddr), .ctl_wdata_i(wdata),
    .ctl_raddr_i(raddr), .ctl_rdata_o(rdata),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .ea_we_o(ea_we), .ea_idx_o(ea_idx), .ea_data_o(ea_data), .pie_o(pie)
  );

  always #2.5 clk = ~clk;

  // {mask[3:0], lines[3:0], pie, expect_take}
  localparam logic [9:0] VEC [NV] = '{
    {4'b0001, 4'b0001, 1'b1, 1'b1},
    {4'b0001, 4'b0001, 1'b0, 1'b0},
    {4'b0010, 4'b0001, 1'b1, 1'b0},
    {4'b0000, 4'b1111, 1'b1, 1'b0},
    {4'b1100, 4'b0100, 1'b1, 1'b1},
    {4'b1111, 4'b0000, 1'b1, 1'b0},
    {4'b1010, 4'b1000, 1'b1, 1'b1},
    {4'b1010, 4'b0101, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); raddr = a;
    @(posedge clk); #1 d = rdata;
  endtask

  task automatic pulse_boundary(input logic [31:0] pc);
    @(negedge clk); boundary = 1'b1; next_pc = pc;
    @(posedge clk); #1;
    @(negedge clk); boundary = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R9 reset state
    check("R9 redirect", {31'd0, redirect}, 32'd0);
    check("R9 ea_we", {31'd0, ea_we}, 32'd0);
    check("R9 pie", {31'd0, pie}, 32'd0);
    csr_read(2'd0, rd); check("R9 status", rd, 32'd0);
    csr_read(2'd1, rd); check("R9 saved", rd, 32'd0);
    csr_read(2'd2, rd); check("R9 mask", rd, 32'd0);
    csr_read(2'd3, rd); check("R9 pending", rd, 32'd0);

    // vector table: R7 decision, R8 status enable, R6 pending
    for (int i = 0; i < NV; i++) begin
      logic [3:0] m, l;
      logic p, e;
      {m, l, p, e} = VEC[i];
      csr_write(2'd0, {31'd0, p});
      csr_write(2'd2, {28'd0, m});
      @(negedge clk); irq = {28'd0, l};
      @(negedge clk);
      @(negedge clk); boundary = 1'b1; next_pc = 32'h100 + 32'(i * 4);
      @(posedge clk); #1;
      check("R7 take", {31'd0, redirect}, {31'd0, e});
      check("R7 ea_we", {31'd0, ea_we}, {31'd0, e});
      if (e) begin
        check("R4 vector", redirect_pc, 32'h20);
        check("R3 ea data", ea_data, 32'h100 + 32'(i * 4));
        check("R3 ea idx", {27'd0, ea_idx}, 32'd29);
      end
      @(negedge clk); boundary = 1'b0;
      csr_read(2'd3, rd); check("R6 pending", rd, {28'd0, m & l});
    end

    // R8: write to pending address has no effect
    csr_write(2'd3, 32'hFFFF_FFFF);
    csr_read(2'd3, rd); check("R8 pending ro", rd, 32'h0000_0000 | {28'd0, 4'b1010 & 4'b0101});

    // R1/R2/R3/R4 entry with full status word
    csr_write(2'd1, 32'h0);
    csr_write(2'd2, 32'h1);
    csr_write(2'd0, 32'hA5);
    @(negedge clk); irq = 32'h1;
    @(negedge clk);
    @(negedge clk); boundary = 1'b1; next_pc = 32'h1004;
    @(posedge clk); #1;
    check("R4 redirect", {31'd0, redirect}, 32'd1);
    check("R4 vector", redirect_pc, 32'h20);
    check("R3 ea_we", {31'd0, ea_we}, 32'd1);
    check("R3 ea data", ea_data, 32'h1004);
    @(negedge clk); boundary = 1'b0;
    @(posedge clk); #1;
    check("R4 one pulse", {31'd0, redirect}, 32'd0);
    check("R3 one pulse", {31'd0, ea_we}, 32'd0);
    csr_read(2'd0, rd); check("R2 status", rd, 32'hA4);
    csr_read(2'd1, rd); check("R1 saved", rd, 32'hA5);

    // R7 nested boundary blocked while enable clear
    pulse_boundary(32'h2000);
    check("R7 nested blocked", {31'd0, redirect}, 32'd0);
    csr_read(2'd1, rd); check("R7 saved kept", rd, 32'hA5);

    // R5 return
    @(negedge clk); eret = 1'b1; ea_in = 32'h1004;
    @(posedge clk); #1;
    check("R5 redirect", {31'd0, redirect}, 32'd1);
    check("R5 target", redirect_pc, 32'h1004);
    check("R5 no ea write", {31'd0, ea_we}, 32'd0);
    @(negedge clk); eret = 1'b0;
    csr_read(2'd0, rd); check("R5 status restored", rd, 32'hA5);

    // R10 return beats a takeable boundary
    @(negedge clk); eret = 1'b1; boundary = 1'b1; ea_in = 32'h3000; next_pc = 32'h4000;
    @(posedge clk); #1;
    check("R10 target", redirect_pc, 32'h3000);
    check("R10 no ea write", {31'd0, ea_we}, 32'd0);
    @(negedge clk); eret = 1'b0; boundary = 1'b0;

    // R10 entry overrides a same-cycle status write
    @(negedge clk); boundary = 1'b1; next_pc = 32'h5000;
    we = 1'b1; waddr = 2'd0; wdata = 32'hFF;
    @(posedge clk); #1;
    check("R10 entry taken", {31'd0, redirect}, 32'd1);
    @(negedge clk); boundary = 1'b0; we = 1'b0;
    csr_read(2'd0, rd); check("R10 status after", rd, 32'hA4);
    check("R10 pie low", {31'd0, pie}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule